// File: doc/BRIEF.md
# Daisy-Chainable Serial Command Port for a Quad 12-Bit DAC

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. A host shifts 16-bit command words in on `din` while `cs_n` is low. When `cs_n` returns high, the block decodes the last 16 bits it received and acts on them. A command can load one channel code, load all four codes, put the part into software shutdown, or wake it from shutdown. The four 12-bit codes and a shutdown flag are the block's outputs toward the analog side.

Every bit shifted in also passes through a 16-bit register and leaves on `dout` exactly one frame later. Several ports can therefore be chained, each `dout` feeding the next port's `din`, on a shared `sclk` and `cs_n`. One `cs_n` rising edge then makes every port in the chain execute the word that has reached it. `dout_mode` chooses whether `dout` moves after the `sclk` rising edge or after the falling edge. The active-low lockout input `pdl_n` has two jobs: it blocks software shutdown while it is low, and a high-to-low transition wakes the part without any serial clocking.

All pins are sampled by the fast system clock `clk` through synchronizers, so all decoding happens in one clock domain.

There are two state machines:
- The frame machine has three states: `FR_IDLE`, `FR_SHIFT` and `FR_EXEC`. It moves from idle to shift when chip select falls. It moves from shift to exec when chip select rises. From exec it goes back to shift if chip select is low again, and to idle otherwise.
- The power machine has two states: `PW_ACTIVE` and `PW_DOWN`. It moves from active to down on an accepted shutdown command. It moves from down to active on a lockout falling edge or on a wake command.

Top module: `dac_serial_port`

## Requirements
- R1: After reset all four codes are zero, `shutdown` is 0 and `dout` is 0.
- R2: Bits are taken MSB first and the frame layout is fixed: bits 15:14 are the channel address, bits 13:12 the operation, and bits 11:0 the data. Operation 01 loads the data into the addressed channel only; channel n occupies `codes[12n+11:12n]`.
- R3: Operation 10 loads the data into all four channels.
- R4: Operation 00 changes neither the codes nor the shutdown flag.
- R5: Codes do not change while `cs_n` is low, even after 16 bits have been clocked in. They change only after `cs_n` rises.
- R6: A frame with fewer or more than 16 `sclk` rising edges is decoded from the last 16 bits shifted in. Those bits may include bits of the previous frame.
- R7: At each `sclk` rising edge, `dout` shows the bit that entered `din` 16 rising edges earlier, so a frame is echoed MSB first one frame later.
- R8: With `dout_mode` = 1, `dout` changes only after an `sclk` rising edge. With `dout_mode` = 0, it changes only after an `sclk` falling edge, or when the frame ends.
- R9: Operation 11 with data bit 11 set raises `shutdown` when `pdl_n` is high; the codes are kept.
- R10: While `pdl_n` is low, shutdown commands are ignored.
- R11: A high-to-low transition of `pdl_n` during shutdown clears `shutdown` without any `sclk` activity. The codes are those held before shutdown.
- R12: While shut down, load commands (01, 10) are ignored.
- R13: Operation 11 with data bit 11 clear clears `shutdown` (software wake).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; `din` is taken on its rising edge |
| cs_n | input | 1 | Active-low chip select framing a command |
| din | input | 1 | Serial data in |
| dout_mode | input | 1 | 1: `dout` moves on `sclk` rise; 0: on `sclk` fall |
| pdl_n | input | 1 | Active-low shutdown lockout and asynchronous wake |
| dout | output | 1 | Serial data out, one frame behind `din` |
| codes | output | 48 | Four 12-bit channel codes, channel 0 in the low bits |
| shutdown | output | 1 | High while in software shutdown |

## Verification
The bench sweeps every channel address with both dout modes, walks a single one through every data bit, and compares each `dout` bit against a 16-bit model shift register before every `sclk` rise and just after it. A wrong field position or address decode would load the wrong channel. A `dout` tap off by one would break the one-frame echo. Swapped edge modes would show the new bit before the falling edge in mode 0.

Frames of 8 and 20 bits check that decoding uses the last 16 bits and not a bit count. A load sent while shut down, and a shutdown sent while `pdl_n` is low, must leave codes and flag alone. A design that dropped the lockout wake, or cleared the codes on shutdown, would show a stuck flag or zeroed outputs after `pdl_n` falls with `sclk` idle.

// File: rtl/dac_port_pkg.sv
package dac_port_pkg;

    // Frame layout: [15:14] channel, [13:12] operation, [11:0] code
    localparam int ADDR_W  = 2;
    localparam int OP_W    = 2;
    localparam int DATA_W  = 12;
    localparam int FRAME_W = ADDR_W + OP_W + DATA_W;
    localparam int NUM_CH  = 1 << ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP      = 2'b00,
        OP_LOAD_ONE = 2'b01,
        OP_LOAD_ALL = 2'b10,
        OP_POWER    = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_EXEC  = 2'd2
    } frame_state_e;

    typedef enum logic {
        PW_ACTIVE = 1'b0,
        PW_DOWN   = 1'b1
    } power_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] chan;
        cmd_op_e           op;
        logic [DATA_W-1:0] value;
    } cmd_word_t;

endpackage

// File: rtl/dac_in_sync.sv
// Multi-bit, per-bit-independent synchronizer chain (STAGES must be >= 2).
module dac_in_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d_in[b]};
            end
        end

        assign q_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/dac_frame_shifter.sv
// Frame shift register with the one-frame-delayed serial echo.
module dac_frame_shifter
    import dac_port_pkg::*;
#(
    parameter int WIDTH = FRAME_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             fall_en,
    input  logic             frame_done,
    input  logic             rise_mode,
    output logic [WIDTH-1:0] frame,
    output logic             dout
);

    logic [WIDTH-1:0] sr_q;
    logic             dout_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[WIDTH-2:0], bit_in};
        end
    end

    // Mode 1 moves the output together with the shift; mode 0 catches the
    // head bit after the falling edge (and at frame end as a safety net).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (rise_mode) begin
            if (shift_en) begin
                dout_q <= sr_q[WIDTH-2];
            end
        end else if (fall_en || frame_done) begin
            dout_q <= sr_q[WIDTH-1];
        end
    end

    assign frame = sr_q;
    assign dout  = dout_q;

endmodule

// File: rtl/dac_cmd_exec.sv
// Channel code registers and the power state machine.
module dac_cmd_exec
    import dac_port_pkg::*;
#(
    parameter int CH = NUM_CH,
    parameter int DW = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec,
    input  cmd_word_t       cmd,
    input  logic            lock_n,
    input  logic            lock_fall,
    output logic [CH*DW-1:0] codes,
    output logic            shutdown
);

    power_state_e pw_q, pw_d;
    logic         is_power_cmd;
    logic         can_load;

    assign is_power_cmd = exec && (cmd.op == OP_POWER);
    assign can_load     = exec && (pw_q == PW_ACTIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_q <= PW_ACTIVE;
        end else begin
            pw_q <= pw_d;
        end
    end

    always_comb begin
        pw_d = pw_q;
        unique case (pw_q)
            PW_ACTIVE: begin
                if (is_power_cmd && cmd.value[DW-1] && lock_n) begin
                    pw_d = PW_DOWN;
                end
            end
            PW_DOWN: begin
                if (lock_fall || (is_power_cmd && !cmd.value[DW-1])) begin
                    pw_d = PW_ACTIVE;
                end
            end
        endcase
    end

    always_comb begin
        shutdown = 1'b0;
        unique case (pw_q)
            PW_ACTIVE: shutdown = 1'b0;
            PW_DOWN:   shutdown = 1'b1;
        endcase
    end

    for (genvar ch = 0; ch < CH; ch++) begin : g_chan
        logic [DW-1:0] code_q;
        logic          wr_en;

        assign wr_en = can_load &&
                       ((cmd.op == OP_LOAD_ALL) ||
                        ((cmd.op == OP_LOAD_ONE) && (cmd.chan == ADDR_W'(ch))));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q <= '0;
            end else if (wr_en) begin
                code_q <= cmd.value;
            end
        end

        assign codes[ch*DW +: DW] = code_q;
    end

endmodule

// File: rtl/dac_serial_port.sv
// Top: pin synchronization, edge detection and the frame state machine.
module dac_serial_port
    import dac_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     cs_n,
    input  logic                     din,
    input  logic                     dout_mode,
    input  logic                     pdl_n,
    output logic                     dout,
    output logic [NUM_CH*DATA_W-1:0] codes,
    output logic                     shutdown
);

    // Synchronized pins: {pdl_n, din, cs_n, sclk}
    localparam logic [3:0] PIN_RST = 4'b1010;

    logic [3:0] pins_s;
    logic       s_sclk, s_cs, s_din, s_pdl;
    logic       p_sclk, p_cs, p_pdl;
    logic       sclk_rise, sclk_fall, pdl_fall;
    logic       shift_en, fall_en;
    logic       exec, frame_done;
    logic [FRAME_W-1:0] frame;
    cmd_word_t  cmd;

    frame_state_e fr_q, fr_d;

    dac_in_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({pdl_n, din, cs_n, sclk}),
        .q_out (pins_s)
    );

    assign s_sclk = pins_s[0];
    assign s_cs   = pins_s[1];
    assign s_din  = pins_s[2];
    assign s_pdl  = pins_s[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_sclk <= 1'b0;
            p_cs   <= 1'b1;
            p_pdl  <= 1'b1;
        end else begin
            p_sclk <= s_sclk;
            p_cs   <= s_cs;
            p_pdl  <= s_pdl;
        end
    end

    assign sclk_rise = s_sclk & ~p_sclk;
    assign sclk_fall = ~s_sclk & p_sclk;
    assign pdl_fall  = ~s_pdl & p_pdl;
    assign shift_en  = sclk_rise & ~s_cs;
    assign fall_en   = sclk_fall & ~s_cs;

    // Frame state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= FR_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    // Frame next-state logic (uses the previous-cycle chip select too)
    always_comb begin
        fr_d = fr_q;
        unique case (fr_q)
            FR_IDLE:  if (!s_cs) fr_d = FR_SHIFT;
            FR_SHIFT: if (s_cs && !p_cs) fr_d = FR_EXEC;
                      else if (s_cs) fr_d = FR_EXEC;
            FR_EXEC:  fr_d = s_cs ? FR_IDLE : FR_SHIFT;
            default:  fr_d = FR_IDLE;
        endcase
    end

    // Frame outputs
    always_comb begin
        exec       = 1'b0;
        frame_done = 1'b0;
        unique case (fr_q)
            FR_IDLE:  ;
            FR_SHIFT: frame_done = s_cs;
            FR_EXEC:  exec = 1'b1;
            default:  ;
        endcase
    end

    dac_frame_shifter #(
        .WIDTH (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .bit_in     (s_din),
        .fall_en    (fall_en),
        .frame_done (frame_done),
        .rise_mode  (dout_mode),
        .frame      (frame),
        .dout       (dout)
    );

    assign cmd = cmd_word_t'(frame);

    dac_cmd_exec #(
        .CH (NUM_CH),
        .DW (DATA_W)
    ) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec      (exec),
        .cmd       (cmd),
        .lock_n    (s_pdl),
        .lock_fall (pdl_fall),
        .codes     (codes),
        .shutdown  (shutdown)
    );

endmodule

// File: rtl/dac_serial_port_chk.sv
module dac_serial_port_chk
    import dac_port_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input frame_state_e             fr_q,
    input logic [NUM_CH*DATA_W-1:0] codes,
    input logic                     shutdown,
    input logic                     dout,
    input logic                     dout_mode,
    input logic                     sclk_rise,
    input logic                     sclk_fall,
    input logic                     frame_done,
    input logic                     s_pdl,
    input logic                     pdl_fall
);

    p_codes_only_after_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q != FR_EXEC) |=> $stable(codes));

    p_no_load_in_shutdown_r12: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> $stable(codes));

    p_lockout_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_pdl && !shutdown) |=> !shutdown);

    p_lockout_wakes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && pdl_fall) |=> !shutdown);

    p_enter_needs_pdl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown) |-> $past(s_pdl));

    p_dout_rise_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_mode && !sclk_rise) |=> $stable(dout));

    p_dout_fall_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dout_mode && !sclk_fall && !frame_done) |=> $stable(dout));

endmodule

bind dac_serial_port dac_serial_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fr_q       (fr_q),
    .codes      (codes),
    .shutdown   (shutdown),
    .dout       (dout),
    .dout_mode  (dout_mode),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .frame_done (frame_done),
    .s_pdl      (s_pdl),
    .pdl_fall   (pdl_fall)
);

// File: tb/dac_serial_port_tb.sv
module dac_serial_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        dout_mode = 1'b1;
    logic        pdl_n = 1'b1;
    logic        dout;
    logic [47:0] codes;
    logic        shutdown;

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;

    logic [15:0] model_sr = '0;
    logic [11:0] exp_code [4];
    bit          exp_sd = 1'b0;

    dac_serial_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .din       (din),
        .dout_mode (dout_mode),
        .pdl_n     (pdl_n),
        .dout      (dout),
        .codes     (codes),
        .shutdown  (shutdown)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_vec();
        logic [47:0] v;
        for (int c = 0; c < 4; c++) v[c*12 +: 12] = exp_code[c];
        return v;
    endfunction

    task automatic check_state(input string req);
        chk(codes == exp_vec(), req, codes, exp_vec());
        chk(shutdown == exp_sd, req, 48'(shutdown), 48'(exp_sd));
    endtask

    // Apply the decode rules to the last 16 bits shifted in
    task automatic model_apply();
        logic [1:0]  a;
        logic [1:0]  op;
        logic [11:0] d;
        a  = model_sr[15:14];
        op = model_sr[13:12];
        d  = model_sr[11:0];
        if (op == 2'b11) begin
            if (d[11] && pdl_n) exp_sd = 1'b1;
            else if (!d[11]) exp_sd = 1'b0;
        end else if (!exp_sd) begin
            if (op == 2'b01) exp_code[a] = d;
            if (op == 2'b10) for (int c = 0; c < 4; c++) exp_code[c] = d;
        end
    endtask

    task automatic begin_frame();
        cs_n = 1'b0;
        tick(8);
    endtask

    // n bits of w, MSB first; dout checked before and after each rise
    task automatic shift_bits(input logic [31:0] w, input int n);
        logic b;
        logic pre;
        for (int i = n - 1; i >= 0; i--) begin
            b = w[i];
            din = b;
            tick(4);
            chk(dout == model_sr[15], "R7 echo before rise", 48'(dout), 48'(model_sr[15]));
            pre = model_sr[15];
            model_sr = {model_sr[14:0], b};
            sclk = 1'b1;
            tick(6);
            if (dout_mode)
                chk(dout == model_sr[15], "R8 mode1 after rise", 48'(dout), 48'(model_sr[15]));
            else
                chk(dout == pre, "R8 mode0 held until fall", 48'(dout), 48'(pre));
            tick(2);
            sclk = 1'b0;
            tick(6);
        end
    endtask

    task automatic end_frame();
        tick(4);
        cs_n = 1'b1;
        tick(10);
        model_apply();
    endtask

    task automatic send(input logic [15:0] w, input string req);
        begin_frame();
        shift_bits(32'(w), 16);
        end_frame();
        check_state(req);
    endtask

    initial begin
        for (int c = 0; c < 4; c++) exp_code[c] = '0;
        tick(5);
        // R1: reset state
        chk(codes == '0, "R1 codes", codes, '0);
        chk(shutdown == 1'b0, "R1 shutdown", 48'(shutdown), '0);
        chk(dout == 1'b0, "R1 dout", 48'(dout), '0);
        rst_n = 1'b1;
        tick(5);

        // R2: per-channel load sweep in mode 1
        dout_mode = 1'b1;
        for (int a = 0; a < 4; a++) begin
            send({2'(a), 2'b01, 12'(12'h111 * (a + 1)) ^ 12'h0A5}, "R2 load one");
        end

        // R5: nothing changes until chip select rises
        begin_frame();
        shift_bits(32'({2'd2, 2'b01, 12'hBEE}), 16);
        tick(12);
        chk(codes == exp_vec(), "R5 held while cs_n low", codes, exp_vec());
        end_frame();
        check_state("R5 applied on cs_n rise");

        // R3 and R2 walking ones in mode 0
        dout_mode = 1'b0;
        tick(4);
        send({2'd1, 2'b10, 12'h5C3}, "R3 load all");
        for (int i = 0; i < 12; i++) begin
            send({2'(i % 4), 2'b01, 12'(1 << i)}, "R2 walking one");
        end
        send({2'd3, 2'b01, 12'hFFF}, "R2 all ones");

        // R4: no-operation
        send(16'h0ABC, "R4 nop");
        send(16'hC0F0, "R4 nop other addr");

        // R6: short and long frames
        send(16'h0093, "R4 nop before short");
        begin_frame();
        shift_bits(32'h5A, 8);
        end_frame();
        check_state("R6 short frame");
        chk(exp_code[2] == 12'h35A, "R6 short decode", 48'(exp_code[2]), 48'h35A);
        begin_frame();
        shift_bits(32'hA5777, 20);
        end_frame();
        check_state("R6 long frame");

        // R9, R12, R11: shutdown, ignored loads, lockout wake
        dout_mode = 1'b1;
        tick(4);
        send(16'h3800, "R9 enter shutdown");
        chk(shutdown == 1'b1, "R9 flag", 48'(shutdown), 48'd1);
        send(16'h1123, "R12 load one ignored");
        send(16'h2FFF, "R12 load all ignored");
        pdl_n = 1'b0;
        tick(8);
        exp_sd = 1'b0;
        check_state("R11 lockout wake");

        // R10: shutdown blocked while lockout low
        send(16'h3FFF, "R10 shutdown ignored");
        pdl_n = 1'b1;
        tick(8);
        check_state("R10 pdl_n rise no effect");

        // R13: software wake
        send(16'h3800, "R9 enter again");
        send(16'h3000, "R13 software wake");
        chk(shutdown == 1'b0, "R13 flag", 48'(shutdown), '0);
        send(16'hD456, "R2 load after wake");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule